// File: doc/BRIEF.md
# Two-Master Register Port Switch

This block lets two masters share one memory-mapped register port. One master is ordinary user logic and the other is a debug agent. A single ownership bit picks which master drives the shared port. After reset the user master owns the port. The debug agent takes the port with a one-cycle acquire pulse and gives it back with a one-cycle release pulse.

Ownership moves only at a clean transaction boundary. A boundary is a cycle in which no read response is still owed, no read is being presented, and no write is sitting stalled on the port. A request that arrives while the port is busy is remembered and takes effect at the first quiet clock edge. The master that does not own the port sees wait-request held high, so its command stays stalled and is never lost. Read responses are sent only to the owner. Because ownership cannot change while a read is outstanding, each response always reaches the master that issued the read.

Top module: `reconfig_bus_switch`

## Requirements
- R1: A synchronous active-high `rst` clears ownership to the user (`dbg_grant`=0), clears the count of outstanding reads and drops any pending acquire request.
- R2: While `dbg_grant`=0, the shared port carries `usr_addr`, `usr_wdata`, `usr_be`, `usr_rd` and `usr_wr`. `usr_wait` equals `shr_wait`, `dbg_wait` is 1, and debug strobes do not reach the port.
- R3: While `dbg_grant`=1, user strobes have no effect on the shared port. The port carries the debug master's signals and `usr_wait` is held at 1.
- R4: An acquire pulse sampled on an edge where the port is quiet sets `dbg_grant` to 1 after that same edge.
- R5: The port is quiet when it owes no read responses, `shr_rd` is low, and `shr_wr` is not stalled by `shr_wait`. A read counts as outstanding from the edge where `shr_rd`=1 and `shr_wait`=0 until the edge with `shr_rvalid`=1. A pending request switches ownership at the first quiet edge and not before.
- R6: A release pulse returns `dbg_grant` to 0 under the same quiet rule.
- R7: `shr_rvalid` and `shr_rdata` are routed only to the current owner. The other master sees read-valid 0 and read data 0.
- R8: If acquire and release are sampled on the same edge, acquire wins.
- R9: A write accepted in a cycle (`shr_wr`=1, `shr_wait`=0) does not block a switch at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_acquire | input | 1 | Pulse: debug agent asks for the port |
| dbg_release | input | 1 | Pulse: debug agent gives the port back |
| dbg_grant | output | 1 | Ownership bit, 1 = debug master owns the port |
| usr_addr | input | AW | User address |
| usr_wdata | input | DW | User write data |
| usr_be | input | DW/8 | User byte enables |
| usr_rd | input | 1 | User read strobe |
| usr_wr | input | 1 | User write strobe |
| usr_rdata | output | DW | Read data to user |
| usr_rvalid | output | 1 | Read-valid to user |
| usr_wait | output | 1 | Wait-request to user |
| dbg_addr | input | AW | Debug address |
| dbg_wdata | input | DW | Debug write data |
| dbg_be | input | DW/8 | Debug byte enables |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_rdata | output | DW | Read data to debug master |
| dbg_rvalid | output | 1 | Read-valid to debug master |
| dbg_wait | output | 1 | Wait-request to debug master |
| shr_addr | output | AW | Shared port address |
| shr_wdata | output | DW | Shared port write data |
| shr_be | output | DW/8 | Shared port byte enables |
| shr_rd | output | 1 | Shared port read strobe |
| shr_wr | output | 1 | Shared port write strobe |
| shr_rdata | input | DW | Shared port read data |
| shr_rvalid | input | 1 | Shared port read-valid |
| shr_wait | input | 1 | Shared port wait-request |

## Verification
Two functions can land in the same cycle: a pending acquire, and the return of the last read response owed to the user. The bench provokes this by issuing one user read, pulsing acquire while that read is outstanding, and then returning the response. The response must reach only the user, and the grant must stay low through the edge that retires the read and rise one edge later. A second collision places a release pulse against a debug write stalled by wait-request. The grant must hold until the edge where the write is accepted.

// File: rtl/reconfig_bus_switch.sv
module reconfig_bus_switch #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_acquire,
  input  logic          dbg_release,
  output logic          dbg_grant,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  input  logic [DW/8-1:0] usr_be,
  input  logic          usr_rd,
  input  logic          usr_wr,
  output logic [DW-1:0] usr_rdata,
  output logic          usr_rvalid,
  output logic          usr_wait,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  input  logic [DW/8-1:0] dbg_be,
  input  logic          dbg_rd,
  input  logic          dbg_wr,
  output logic [DW-1:0] dbg_rdata,
  output logic          dbg_rvalid,
  output logic          dbg_wait,
  output logic [AW-1:0] shr_addr,
  output logic [DW-1:0] shr_wdata,
  output logic [DW/8-1:0] shr_be,
  output logic          shr_rd,
  output logic          shr_wr,
  input  logic [DW-1:0] shr_rdata,
  input  logic          shr_rvalid,
  input  logic          shr_wait
);
  logic          mode, want;
  logic [CW-1:0] rd_cnt;

  wire rd_acc  = shr_rd & ~shr_wait;
  wire quiet   = (rd_cnt == '0) & ~shr_rd & ~(shr_wr & shr_wait);
  wire want_nx = dbg_acquire ? 1'b1 : (dbg_release ? 1'b0 : want);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= 1'b0;
      want   <= 1'b0;
      rd_cnt <= '0;
    end else begin
      want <= want_nx;
      if (quiet) mode <= want_nx;
      case ({rd_acc, shr_rvalid})
        2'b10:   rd_cnt <= rd_cnt + 1'b1;
        2'b01:   rd_cnt <= rd_cnt - 1'b1;
        default: rd_cnt <= rd_cnt;
      endcase
    end
  end

  assign dbg_grant  = mode;
  assign shr_addr   = mode ? dbg_addr  : usr_addr;
  assign shr_wdata  = mode ? dbg_wdata : usr_wdata;
  assign shr_be     = mode ? dbg_be    : usr_be;
  assign shr_rd     = mode ? dbg_rd    : usr_rd;
  assign shr_wr     = mode ? dbg_wr    : usr_wr;

  assign usr_wait   = mode ? 1'b1 : shr_wait;
  assign dbg_wait   = mode ? shr_wait : 1'b1;
  assign usr_rvalid = ~mode & shr_rvalid;
  assign dbg_rvalid =  mode & shr_rvalid;
  assign usr_rdata  = mode ? '0 : shr_rdata;
  assign dbg_rdata  = mode ? shr_rdata : '0;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!dbg_grant && rd_cnt == '0 && !want)); // R1
  AST_USER_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    dbg_grant |-> (usr_wait && !usr_rvalid)); // R3
  AST_DEBUG_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !dbg_grant |-> (dbg_wait && !dbg_rvalid)); // R2
  AST_NO_SWITCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$stable(dbg_grant) |-> ($past(rd_cnt) == '0 && !$past(shr_rd))); // R5
  AST_STALLED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (shr_wr && shr_wait) |=> $stable(dbg_grant)); // R9
  AST_USER_RD_ONLY_OWNER: assert property (@(posedge clk) disable iff (rst)
    (dbg_grant && shr_rd) |-> dbg_rd); // R3
endmodule

// File: tb/tb_reconfig_bus_switch.sv
module tb_reconfig_bus_switch;
  localparam int AW = 16, DW = 32, BW = DW/8;
  logic clk = 0, rst = 1;
  logic dbg_acquire = 0, dbg_release = 0, dbg_grant;
  logic [AW-1:0] usr_addr = '0, dbg_addr = '0, shr_addr;
  logic [DW-1:0] usr_wdata = '0, dbg_wdata = '0, shr_wdata, shr_rdata = '0;
  logic [BW-1:0] usr_be = '0, dbg_be = '0, shr_be;
  logic usr_rd = 0, usr_wr = 0, dbg_rd = 0, dbg_wr = 0;
  logic [DW-1:0] usr_rdata, dbg_rdata;
  logic usr_rvalid, usr_wait, dbg_rvalid, dbg_wait, shr_rd, shr_wr;
  logic shr_rvalid = 0, shr_wait = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  reconfig_bus_switch #(.AW(AW), .DW(DW), .CW(4)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0; #1;
    chk(dbg_grant == 0, "R1 grant after reset", dbg_grant, 0);
    shr_wait = 1; #1;
    chk(usr_wait == 1 && dbg_wait == 1, "R2 wait routing", {usr_wait, dbg_wait}, 2'b11);
    shr_wait = 0; #1;
    chk(usr_wait == 0 && dbg_wait == 1, "R2 wait routing idle", {usr_wait, dbg_wait}, 2'b01);
  endtask

  task automatic t_user_route();
    usr_addr = 16'h1234; usr_wdata = 32'hCAFE0001; usr_be = 4'hA; usr_wr = 1;
    dbg_addr = 16'h0BAD; dbg_rd = 1; #1;
    chk(shr_addr == 16'h1234 && shr_wdata == 32'hCAFE0001 && shr_be == 4'hA,
        "R2 user fields", {shr_addr, shr_be}, {16'h1234, 4'hA});
    chk(shr_wr == 1 && shr_rd == 0, "R2 user strobes only", {shr_wr, shr_rd}, 2'b10);
    step(); usr_wr = 0; dbg_rd = 0; #1;
    chk(shr_wr == 0 && shr_rd == 0, "R2 idle strobes low", {shr_wr, shr_rd}, 0);
  endtask

  task automatic t_acquire_vs_response();
    usr_rd = 1; usr_addr = 16'h0040; step();
    usr_rd = 0; dbg_acquire = 1; step();
    dbg_acquire = 0; #1;
    chk(dbg_grant == 0, "R5 held while read outstanding", dbg_grant, 0);
    shr_rvalid = 1; shr_rdata = 32'h5A5A1111; #1;
    chk(usr_rvalid == 1 && usr_rdata == 32'h5A5A1111 && dbg_rvalid == 0,
        "R7 response to user", usr_rdata, 32'h5A5A1111);
    step(); shr_rvalid = 0; #1;
    chk(dbg_grant == 0, "R5 no switch on retiring edge", dbg_grant, 0);
    step();
    chk(dbg_grant == 1, "R4 grant at first quiet edge", dbg_grant, 1);
  endtask

  task automatic t_debug_owner();
    usr_wr = 1; usr_addr = 16'h7777; dbg_wr = 0; #1;
    chk(shr_wr == 0 && usr_wait == 1, "R3 user strobe blocked", {shr_wr, usr_wait}, 2'b01);
    dbg_wr = 1; dbg_addr = 16'h00F0; dbg_wdata = 32'h0D0D0D0D; #1;
    chk(shr_wr == 1 && shr_addr == 16'h00F0 && shr_wdata == 32'h0D0D0D0D,
        "R3 debug fields", shr_addr, 16'h00F0);
    step(); dbg_wr = 0; usr_wr = 0;
    shr_rvalid = 1; shr_rdata = 32'h9999AAAA; #1;
    chk(dbg_rvalid == 1 && usr_rvalid == 0 && usr_rdata == 0 && dbg_rdata == 32'h9999AAAA,
        "R7 response to debug", {usr_rvalid, dbg_rvalid}, 2'b01);
    shr_rvalid = 0; shr_rdata = 0;
  endtask

  task automatic t_release_stalled();
    dbg_wr = 1; shr_wait = 1; dbg_release = 1; step();
    dbg_release = 0; #1;
    chk(dbg_grant == 1, "R9 held by stalled write", dbg_grant, 1);
    step();
    chk(dbg_grant == 1, "R9 still held", dbg_grant, 1);
    shr_wait = 0; #1;
    chk(dbg_wait == 0, "R3 debug sees wait low", dbg_wait, 0);
    step(); dbg_wr = 0; #1;
    chk(dbg_grant == 0, "R6 release at accepted write", dbg_grant, 0);
  endtask

  task automatic t_both_pulses();
    dbg_acquire = 1; dbg_release = 1; step();
    dbg_acquire = 0; dbg_release = 0; #1;
    chk(dbg_grant == 1, "R8 acquire wins", dbg_grant, 1);
    dbg_release = 1; step(); dbg_release = 0; #1;
    chk(dbg_grant == 0, "R6 plain release", dbg_grant, 0);
  endtask

  task automatic t_reset_drops();
    usr_rd = 1; step(); usr_rd = 0; dbg_acquire = 1; step(); dbg_acquire = 0;
    rst = 1; step(); rst = 0; step(); step(); step();
    chk(dbg_grant == 0, "R1 pending request dropped", dbg_grant, 0);
    dbg_acquire = 1; step(); dbg_acquire = 0; #1;
    chk(dbg_grant == 1, "R1 read count cleared", dbg_grant, 1);
  endtask

  initial begin
    t_reset();
    t_user_route();
    t_acquire_vs_response();
    t_debug_owner();
    t_release_stalled();
    t_both_pulses();
    t_reset_drops();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule